// File: doc/BRIEF.md
# Paired Down-Counter PWM Timer

This peripheral holds two reloadable counters on a small register bus and combines them into one pulse-width-modulated output. The first counter sets the repeat interval of the waveform and the second sets how long the output stays high in each interval. Each counter has three registers: a control/status word, a reload value and the live count. Software programs both reload values, primes each counter with a one-shot load bit, and then starts both counters on the same clock edge with a start-both bit.

Each counter wraps and reloads itself, and it can raise a one-cycle event strobe each time it wraps. In PWM mode the first counter's strobe drives the output high and also restarts the second counter, so the high phase is timed from the start of each interval. The second counter's strobe then drives the output low. If only the first counter runs, the output sits high. If only the second runs, it sits low. If either control word lacks the PWM setup, the output is forced low.

Top module: `dual_timer_pwm`

## Requirements
- R1: After reset every register reads zero, both event strobes are low and the PWM output is low.
- R2: Byte offsets: counter 0 uses 0x00 (control), 0x04 (reload) and 0x08 (count); counter 1 uses 0x10, 0x14 and 0x18; offsets 0x0C and 0x1C read zero. A reload write keeps only the low CNT_W bits. Control bits 5 and 10 always read back as zero.
- R3: Writing a control word with bit 5 set copies that counter's reload value into its count on that edge, once. A later change to the reload value does not alter a stopped count.
- R4: While control bit 7 (run) is set and bit 1 is set, the count falls by one each clock. From zero it shows all ones for one wrap cycle and then reloads, so one period lasts reload+2 cycles.
- R5: In each wrap cycle the counter's event strobe is high for exactly one cycle when control bit 2 is set. Status bit 8 sets after each wrap and is cleared by writing 1 to it.
- R6: With control bit 4 (auto-reload) clear, the wrap clears run and the count holds at its wrapped value.
- R7: With bit 1 clear the counter counts up. From all ones it wraps to zero and then reloads, so one period lasts (2^CNT_W-1-reload)+2 cycles.
- R8: A control write with bit 10 set, to either counter, sets run in both counters on the same edge.
- R9: PWM mode needs bits 1, 2, 4 and 9 set in both control words. Without that, the output is low from the next cycle.
- R10: In PWM mode the output rises one cycle after counter 0's strobe, which also restarts counter 1. It falls one cycle after counter 1's strobe. The period is reload0+2 cycles and the high time is reload1+2 cycles.
- R11: In PWM mode with only counter 0 running, the output stays high. With only counter 1 running, it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| gen_o | output | 2 | Event strobes of counter 1 and counter 0 |
| pwm_o | output | 1 | Combined PWM output |

## Verification
A count or wrap flag that goes wrong shows up within one period as an event strobe in the wrong cycle. The count register also reads the wrong value as soon as it is selected. If counter 1 misses its restart, the high time drifts, and the PWM edges move away from a behavioural model that is compared on every clock. A lost or stuck status, run or load bit shows at the next read of that control word, and the measured period or high time shows it within one interval.

// File: rtl/dtp_pkg.sv
package dtp_pkg;

    localparam int NUM_TMR = 2;
    localparam int CTL_W   = 12;

    localparam int BIT_MODE  = 0;
    localparam int BIT_DOWN  = 1;
    localparam int BIT_GEN   = 2;
    localparam int BIT_CAPT  = 3;
    localparam int BIT_AUTO  = 4;
    localparam int BIT_LOAD  = 5;
    localparam int BIT_IRQEN = 6;
    localparam int BIT_RUN   = 7;
    localparam int BIT_FLAG  = 8;
    localparam int BIT_PWM   = 9;
    localparam int BIT_ALL   = 10;
    localparam int BIT_CASC  = 11;

    // Stored control fields; load and start-both are strobes and are not kept.
    typedef struct packed {
        logic cascade;
        logic pwm_en;
        logic flag;
        logic run;
        logic irq_en;
        logic reload_auto;
        logic capture;
        logic gen_en;
        logic count_down;
        logic mode_sel;
    } ctl_t;

    function automatic logic [CTL_W-1:0] ctl_to_word(input ctl_t c);
        logic [CTL_W-1:0] w;
        w            = '0;
        w[BIT_MODE]  = c.mode_sel;
        w[BIT_DOWN]  = c.count_down;
        w[BIT_GEN]   = c.gen_en;
        w[BIT_CAPT]  = c.capture;
        w[BIT_AUTO]  = c.reload_auto;
        w[BIT_IRQEN] = c.irq_en;
        w[BIT_RUN]   = c.run;
        w[BIT_FLAG]  = c.flag;
        w[BIT_PWM]   = c.pwm_en;
        w[BIT_CASC]  = c.cascade;
        return w;
    endfunction

endpackage

// File: rtl/dtp_timer.sv
module dtp_timer
    import dtp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ld_wr,
    input  logic [31:0]      wr_val,
    input  logic             run_all,
    input  logic             restart,
    output logic [CTL_W-1:0] ctl_word,
    output logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_val,
    output logic             gen_pulse,
    output logic             pwm_ready
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ld;
        logic             wrap;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       spare_unused;

    assign spare_unused = ^wr_val;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;

        // count path: one-shot load, then restart, then normal stepping
        if (ctl_wr && wr_val[BIT_LOAD]) begin
            st_d.cnt = st_q.ld;
        end else if (restart) begin
            st_d.cnt = st_q.ld;
        end else if (st_q.ctl.run) begin
            if (st_q.wrap) begin
                if (st_q.ctl.reload_auto) begin
                    st_d.cnt = st_q.ld;
                end else begin
                    st_d.ctl.run = 1'b0;
                end
            end else if (st_q.ctl.count_down) begin
                if (st_q.cnt == '0) begin
                    st_d.cnt  = CNT_MAX;
                    st_d.wrap = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_ONE;
                end
            end else begin
                if (st_q.cnt == CNT_MAX) begin
                    st_d.cnt  = '0;
                    st_d.wrap = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_ONE;
                end
            end
        end

        // control path: software write, wrap status, start-both
        if (ctl_wr) begin
            st_d.ctl.mode_sel    = wr_val[BIT_MODE];
            st_d.ctl.count_down  = wr_val[BIT_DOWN];
            st_d.ctl.gen_en      = wr_val[BIT_GEN];
            st_d.ctl.capture     = wr_val[BIT_CAPT];
            st_d.ctl.reload_auto = wr_val[BIT_AUTO];
            st_d.ctl.irq_en      = wr_val[BIT_IRQEN];
            st_d.ctl.run         = wr_val[BIT_RUN];
            st_d.ctl.flag        = st_q.ctl.flag & ~wr_val[BIT_FLAG];
            st_d.ctl.pwm_en      = wr_val[BIT_PWM];
            st_d.ctl.cascade     = wr_val[BIT_CASC];
        end
        if (st_q.wrap) begin
            st_d.ctl.flag = 1'b1;
        end
        if (run_all) begin
            st_d.ctl.run = 1'b1;
        end

        if (ld_wr) begin
            st_d.ld = wr_val[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_word  = ctl_to_word(st_q.ctl);
    assign load_val  = st_q.ld;
    assign count_val = st_q.cnt;
    assign gen_pulse = st_q.wrap & st_q.ctl.gen_en;
    assign pwm_ready = st_q.ctl.count_down & st_q.ctl.gen_en &
                       st_q.ctl.reload_auto & st_q.ctl.pwm_en;

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_val[BIT_LOAD]) |=> (count_val == $past(load_val))); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_word[BIT_RUN] && !ctl_wr && !restart) |=> $stable(count_val)); // R4

    AST_GEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        gen_pulse |=> !gen_pulse); // R5

    AST_WRAP_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wrap && $past(ctl_word[BIT_DOWN])) |-> (count_val == CNT_MAX)); // R4

endmodule

// File: rtl/dtp_pwm_out.sv
module dtp_pwm_out (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_ok,
    input  logic set_pulse,
    input  logic clr_pulse,
    output logic pwm_o
);

    typedef struct packed {
        logic level;
    } out_state_t;

    out_state_t os_d, os_q;

    always_comb begin
        os_d = os_q;
        if (!cfg_ok) begin
            os_d.level = 1'b0;
        end else if (set_pulse) begin
            os_d.level = 1'b1;
        end else if (clr_pulse) begin
            os_d.level = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign pwm_o = os_q.level;

    AST_UNCFG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |=> !pwm_o); // R9

    AST_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> $past(set_pulse)); // R10

    AST_FALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_o) |-> $past(clr_pulse || !cfg_ok)); // R10

endmodule

// File: rtl/dual_timer_pwm.sv
module dual_timer_pwm
    import dtp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [1:0]  gen_o,
    output logic        pwm_o
);

    localparam logic [1:0] REG_CTL = 2'd0;
    localparam logic [1:0] REG_LD  = 2'd1;
    localparam logic [1:0] REG_CNT = 2'd2;

    logic             sel_tmr;
    logic [1:0]       sel_reg;
    logic             start_both;
    logic             cfg_ok;
    logic             addr_unused;
    logic [NUM_TMR-1:0] gen_w;
    logic [NUM_TMR-1:0] rdy_w;
    logic [NUM_TMR-1:0] restart_v;
    logic [CTL_W-1:0] ctl_w [NUM_TMR];
    logic [CNT_W-1:0] ld_w  [NUM_TMR];
    logic [CNT_W-1:0] cnt_w [NUM_TMR];

    assign sel_tmr     = bus_addr[4];
    assign sel_reg     = bus_addr[3:2];
    assign addr_unused = ^bus_addr[1:0];
    assign start_both  = bus_wr && (sel_reg == REG_CTL) && bus_wdata[BIT_ALL];
    assign cfg_ok      = &rdy_w;
    // counter 1 restarts its high phase on counter 0's strobe in PWM mode
    assign restart_v   = {cfg_ok & gen_w[0], 1'b0};

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        logic ctl_sel;
        logic ld_sel;
        assign ctl_sel = bus_wr && (sel_tmr == 1'(t)) && (sel_reg == REG_CTL);
        assign ld_sel  = bus_wr && (sel_tmr == 1'(t)) && (sel_reg == REG_LD);

        dtp_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_wr    (ctl_sel),
            .ld_wr     (ld_sel),
            .wr_val    (bus_wdata),
            .run_all   (start_both),
            .restart   (restart_v[t]),
            .ctl_word  (ctl_w[t]),
            .load_val  (ld_w[t]),
            .count_val (cnt_w[t]),
            .gen_pulse (gen_w[t]),
            .pwm_ready (rdy_w[t])
        );
    end

    dtp_pwm_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_ok    (cfg_ok),
        .set_pulse (gen_w[0]),
        .clr_pulse (gen_w[1]),
        .pwm_o     (pwm_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel_reg)
            REG_CTL: bus_rdata = 32'(ctl_w[sel_tmr]);
            REG_LD:  bus_rdata = 32'(ld_w[sel_tmr]);
            REG_CNT: bus_rdata = 32'(cnt_w[sel_tmr]);
            default: bus_rdata = '0;
        endcase
    end

    assign gen_o = gen_w;

    AST_START_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        start_both |=> (ctl_w[0][BIT_RUN] && ctl_w[1][BIT_RUN])); // R8

    AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_v[1] && !(bus_wr && sel_tmr && sel_reg == REG_CTL))
        |=> (cnt_w[1] == $past(ld_w[1]))); // R10

endmodule

// File: tb/dual_timer_pwm_test.sv
`timescale 1ns/1ps
module dual_timer_pwm_test;

    localparam int W  = 16;
    localparam int MX = (1 << W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  gen_o;
    logic        pwm_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    int          m_cnt [2] = '{0, 0};
    int          m_ld  [2] = '{0, 0};
    logic [11:0] m_ctl [2] = '{12'h0, 12'h0};
    bit          m_wrap[2] = '{1'b0, 1'b0};
    bit          m_pwm = 1'b0;

    always #2 clk = ~clk;

    dual_timer_pwm #(.CNT_W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gen_o     (gen_o),
        .pwm_o     (pwm_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin : model
        int  nc [2];
        int  nl [2];
        logic [11:0] nt [2];
        bit  nw [2];
        bit  g  [2];
        bit  ok;
        bit  ctlw;
        bit  ldw;
        bit  all;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 0; m_ld[i] = 0; m_ctl[i] = 12'h0; m_wrap[i] = 1'b0;
            end
            m_pwm = 1'b0;
        end else begin
            for (int i = 0; i < 2; i++) g[i] = m_wrap[i] && m_ctl[i][2];
            ok  = ((m_ctl[0] & 12'h216) == 12'h216) && ((m_ctl[1] & 12'h216) == 12'h216);
            all = bus_wr && (bus_addr[3:2] == 2'd0) && bus_wdata[10];
            for (int i = 0; i < 2; i++) begin
                ctlw = bus_wr && (int'(bus_addr[4]) == i) && (bus_addr[3:2] == 2'd0);
                ldw  = bus_wr && (int'(bus_addr[4]) == i) && (bus_addr[3:2] == 2'd1);
                nc[i] = m_cnt[i]; nl[i] = m_ld[i]; nt[i] = m_ctl[i]; nw[i] = 1'b0;
                if (ctlw && bus_wdata[5]) nc[i] = m_ld[i];
                else if (i == 1 && ok && g[0]) nc[i] = m_ld[i];
                else if (m_ctl[i][7]) begin
                    if (m_wrap[i]) begin
                        if (m_ctl[i][4]) nc[i] = m_ld[i];
                        else nt[i][7] = 1'b0;
                    end else if (m_ctl[i][1]) begin
                        if (m_cnt[i] == 0) begin nc[i] = MX; nw[i] = 1'b1; end
                        else nc[i] = m_cnt[i] - 1;
                    end else begin
                        if (m_cnt[i] == MX) begin nc[i] = 0; nw[i] = 1'b1; end
                        else nc[i] = m_cnt[i] + 1;
                    end
                end
                if (ctlw) nt[i] = (bus_wdata[11:0] & 12'hADF) |
                                  ((m_ctl[i][8] && !bus_wdata[8]) ? 12'h100 : 12'h000);
                if (m_wrap[i]) nt[i][8] = 1'b1;
                if (all) nt[i][7] = 1'b1;
                if (ldw) nl[i] = int'(bus_wdata) & MX;
            end
            m_pwm = !ok ? 1'b0 : g[0] ? 1'b1 : g[1] ? 1'b0 : m_pwm;
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = nc[i]; m_ld[i] = nl[i]; m_ctl[i] = nt[i]; m_wrap[i] = nw[i];
            end
        end
    end

    // per-cycle comparison against the reference, away from the edge
    initial begin
        forever begin
            logic [31:0] er;
            int idx;
            @(posedge clk);
            #1;
            idx = int'(bus_addr[4]);
            case (bus_addr[3:2])
                2'd0:    er = 32'(m_ctl[idx]);
                2'd1:    er = 32'(m_ld[idx]);
                2'd2:    er = 32'(m_cnt[idx]);
                default: er = 32'h0;
            endcase
            chk("R10 pwm_o vs model", 32'(pwm_o), 32'(m_pwm));
            chk("R5 gen_o vs model", 32'(gen_o),
                {30'h0, m_wrap[1] && m_ctl[1][2], m_wrap[0] && m_ctl[0][2]});
            chk("R2 bus_rdata vs model", bus_rdata, er);
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic gap(input int idx, output int n);
        n = 0;
        do begin @(posedge clk); #1; end while (gen_o[idx] !== 1'b1);
        do begin @(posedge clk); #1; n++; end while (gen_o[idx] !== 1'b1);
    endtask

    task automatic pwm_meas(output int hi, output int per);
        do begin @(posedge clk); #1; end while (pwm_o !== 1'b0);
        do begin @(posedge clk); #1; end while (pwm_o !== 1'b1);
        hi = 0;
        do begin hi++; @(posedge clk); #1; end while (pwm_o === 1'b1);
        per = hi;
        do begin per++; @(posedge clk); #1; end while (pwm_o === 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, run incomplete (all requirements)");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, hi, per;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, 32'h0, "R1 ctrl0 after reset");
        rd(5'h18, 32'h0, "R1 count1 after reset");
        chk("R1 pwm_o after reset", 32'(pwm_o), 32'h0);
        chk("R1 gen_o after reset", 32'(gen_o), 32'h0);

        // R2 map and readback
        wr(5'h14, 32'h0001_2345);
        rd(5'h14, 32'h0000_2345, "R2 reload keeps low CNT_W bits");
        wr(5'h10, 32'h0000_0A36);
        rd(5'h10, 32'h0000_0A16, "R2 ctrl1 load bit reads zero");
        rd(5'h18, 32'h0000_2345, "R3 load bit primes count1");
        rd(5'h0C, 32'h0, "R2 unused offset reads zero");
        wr(5'h10, 32'h0);

        // R3 one-shot load on a stopped counter
        wr(5'h04, 32'd5);
        wr(5'h00, 32'h20);
        rd(5'h08, 32'd5, "R3 count0 after load");
        wr(5'h04, 32'd9);
        rd(5'h08, 32'd5, "R3 no reload without load bit");
        rd(5'h00, 32'h0, "R2 ctrl0 load bit reads zero");

        // R4 / R5 down-count period and status flag
        wr(5'h00, 32'h96);
        gap(0, n);
        chk("R4 down period reload+2", 32'(n), 32'd11);
        gap(0, n);
        chk("R4 down period repeats", 32'(n), 32'd11);
        rd(5'h00, 32'h196, "R5 status flag set after wrap");
        wr(5'h00, 32'h016);
        repeat (4) @(negedge clk);
        wr(5'h00, 32'h116);
        rd(5'h00, 32'h016, "R5 write one clears flag");

        // R6 no auto-reload
        wr(5'h04, 32'd3);
        wr(5'h00, 32'hA6);
        repeat (10) @(negedge clk);
        rd(5'h08, 32'h0000_FFFF, "R6 count holds wrapped value");
        rd(5'h00, 32'h106, "R6 run cleared, flag set");

        // R7 up count
        wr(5'h14, 32'h0000_FFFD);
        wr(5'h10, 32'hB4);
        gap(1, n);
        chk("R7 up period", 32'(n), 32'd4);
        wr(5'h10, 32'h0);

        // R8 start both, R10 waveform
        wr(5'h04, 32'd7);
        wr(5'h00, 32'h336);
        wr(5'h14, 32'd2);
        wr(5'h10, 32'h336);
        wr(5'h10, 32'h616);
        rd(5'h00, 32'h296, "R8 counter 0 started");
        rd(5'h10, 32'h296, "R8 counter 1 started");
        pwm_meas(hi, per);
        chk("R10 high time reload1+2", 32'(hi), 32'd4);
        chk("R10 period reload0+2", 32'(per), 32'd9);
        pwm_meas(hi, per);
        chk("R10 high time repeats", 32'(hi), 32'd4);
        chk("R10 period repeats", 32'(per), 32'd9);

        // R9 incomplete setup forces low
        wr(5'h10, 32'h096);
        @(posedge clk); #1;
        chk("R9 pwm low after setup broken", 32'(pwm_o), 32'h0);
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); #1;
            chk("R9 pwm stays low", 32'(pwm_o), 32'h0);
        end

        // R11 steady levels
        wr(5'h10, 32'h216);
        repeat (20) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); #1;
            chk("R11 only counter 0 running: high", 32'(pwm_o), 32'h1);
        end
        wr(5'h00, 32'h216);
        wr(5'h10, 32'h296);
        repeat (20) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); #1;
            chk("R11 only counter 1 running: low", 32'(pwm_o), 32'h0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule